// File: doc/BRIEF.md
# Native AUX Request Sequencer

This block runs one native read or native write transaction against a display sink's configuration space. A caller hands it a 16-bit register address, a direction, a byte count and, for writes, the payload. The sequencer packs a four-byte request header in front of the payload, presents the message to a lower-level channel engine, and then reads that engine's reply. The engine handles the line coding. The sequencer decides from the reply what happens next: finish, re-issue at once, wait and re-issue, or give up. It reports the outcome with a one-cycle done pulse that carries a result code, the number of bytes delivered and the received data.

The retry policy treats two cases differently. When the channel engine reports that it is busy, the request is presented again on the next cycle. When the sink answers with a defer, the sequencer first waits 400 µs, counted in clock cycles derived from the clock frequency parameter, and then presents the request again. Both kinds of retry draw on one budget of attempts per transaction.

Top module: `auxq_seq`

## Requirements
- R1: On `ch_msg`, byte k occupies bits [8k+7:8k]. Byte 0 is the address low byte and byte 1 is the address high byte. Byte 2 is the command code shifted into its upper nibble: 0x80 for a write, 0x90 for a read. Byte 3 carries the low 4 bits of the total message length in its upper nibble and the byte count minus one in its lower nibble.
- R2: A write message carries its payload in bytes 4 and up, with `ch_msg_len` = count + 4. Payload bytes at or beyond the count are zero. A read message has no payload, and both its length nibble and `ch_msg_len` are 4.
- R3: A count of 0 or above MAXB (16) is rejected. Done rises one cycle after acceptance with code 4, and no channel request is made.
- R4: `rsp_status` 1 (timeout) ends the transaction with code 1. `rsp_status` 3 (error) ends it with code 2. In both cases done is asserted on the cycle after the reply handshake.
- R5: `rsp_status` 2 (busy) makes the request valid again on the cycle right after the reply handshake.
- R6: A good status (0) with `rsp_ack` 2 (defer) holds off the next request for WAIT_CYC = CLK_FREQ/2500 cycles.
- R7: A transaction makes at most MAX_TRIES (4) attempts. A busy or defer reply on the last attempt ends it with code 2 (I/O error).
- R8: A good status with `rsp_ack` 1 (nack) or 3 (invalid) ends the transaction with code 2.
- R9: A read whose acknowledged reply carries zero bytes ends with code 3 (protocol error).
- R10: An acknowledged read returns code 0 with `rd_count` = min(`rsp_len`, count); data bytes at or beyond `rd_count` are zero. An acknowledged write returns code 0, `rd_count` = count and zero data.
- R11: `done` is a single-cycle pulse. `req_ready` is high only while idle, and never together with `ch_valid`. A pending `ch_msg` stays stable while `ch_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Caller request valid |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_len | input | 5 | Byte count |
| req_wdata | input | 128 | Write payload, byte 0 in bits [7:0] |
| ch_valid | output | 1 | Message offered to channel engine |
| ch_ready | input | 1 | Channel engine takes message |
| ch_msg | output | 160 | Header plus payload |
| ch_msg_len | output | 5 | Total message bytes |
| rsp_valid | input | 1 | Channel reply valid |
| rsp_ready | output | 1 | Sequencer waiting for reply |
| rsp_status | input | 2 | 0 ok, 1 timeout, 2 busy, 3 error |
| rsp_ack | input | 2 | 0 ack, 1 nack, 2 defer, 3 invalid |
| rsp_len | input | 5 | Reply data bytes |
| rsp_data | input | 128 | Reply data |
| done | output | 1 | Transaction finished (pulse) |
| done_code | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 protocol, 4 rejected |
| rd_count | output | 5 | Bytes delivered |
| rd_data | output | 128 | Delivered bytes, zero-filled |

## Verification
Each result has a fixed due cycle:

- **Channel request:** visible the cycle after the caller handshake.
- **Rejection:** done is visible the cycle after the caller handshake.
- **Outcome:** every final outcome shows on done the cycle after the reply handshake.
- **Busy retry:** the request is re-offered that same next cycle.
- **Defer retry:** the request is re-offered WAIT_CYC cycles later.

The bench predicts the attempt count, each inter-attempt gap, the final code, the count and the data from the scripted replies. It samples at falling edges and counts the cycles between handshakes, so every gap and every done is checked exactly in its due cycle. A falling-edge monitor also confirms that each transaction produces exactly one done pulse.

// File: rtl/auxq_pkg.sv
package auxq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WRSP, ST_WDEF} auxq_state_e;

  localparam logic [1:0] CH_OK      = 2'd0;
  localparam logic [1:0] CH_TIMEOUT = 2'd1;
  localparam logic [1:0] CH_BUSY    = 2'd2;
  localparam logic [1:0] CH_ERROR   = 2'd3;

  localparam logic [1:0] ACK_OK    = 2'd0;
  localparam logic [1:0] ACK_NACK  = 2'd1;
  localparam logic [1:0] ACK_DEFER = 2'd2;

  localparam logic [2:0] RES_OK      = 3'd0;
  localparam logic [2:0] RES_TIMEOUT = 3'd1;
  localparam logic [2:0] RES_IO      = 3'd2;
  localparam logic [2:0] RES_PROTO   = 3'd3;
  localparam logic [2:0] RES_REJECT  = 3'd4;

  localparam logic [3:0] CMD_WR = 4'h8;
  localparam logic [3:0] CMD_RD = 4'h9;
endpackage

// File: rtl/auxq_hdr.sv
module auxq_hdr
  import auxq_pkg::*;
#(
  parameter int MAXB = 16,
  parameter int LW   = $clog2(MAXB + 1),
  parameter int ML   = $clog2(MAXB + 5),
  parameter int MW   = 8 * (MAXB + 4),
  parameter int DW   = 8 * MAXB
) (
  input  logic          is_write,
  input  logic [15:0]   addr,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] wdata,
  output logic [MW-1:0] msg,
  output logic [ML-1:0] msg_len
);
  logic [ML-1:0] total;
  logic [LW-1:0] len_m1;

  always_comb begin
    total  = is_write ? (ML'(len) + ML'(4)) : ML'(4);
    len_m1 = len - LW'(1);
    msg    = '0;
    msg[7:0]   = addr[7:0];
    msg[15:8]  = addr[15:8];
    msg[23:16] = {(is_write ? CMD_WR : CMD_RD), 4'h0};
    msg[31:24] = {total[3:0], len_m1[3:0]};
    for (int i = 0; i < MAXB; i++) begin
      if (is_write && (i < int'(len)))
        msg[32+8*i +: 8] = wdata[8*i +: 8];
    end
    msg_len = total;
  end
endmodule

// File: rtl/auxq_timer.sv
module auxq_timer #(
  parameter int W  = 20000,
  parameter int CW = $clog2(W + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (start)             cnt <= CW'(W);
    else if (run && cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign expired = run && (cnt == CW'(1));

  assert_wait_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(W));
  assert_wait_counts_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !start && cnt > CW'(1)) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/auxq_seq.sv
module auxq_seq
  import auxq_pkg::*;
#(
  parameter int MAXB      = 16,
  parameter int CLK_FREQ  = 50_000_000,
  parameter int MAX_TRIES = 4,
  localparam int LW = $clog2(MAXB + 1),
  localparam int ML = $clog2(MAXB + 5),
  localparam int MW = 8 * (MAXB + 4),
  localparam int DW = 8 * MAXB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [15:0]   req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [DW-1:0] req_wdata,
  output logic          ch_valid,
  input  logic          ch_ready,
  output logic [MW-1:0] ch_msg,
  output logic [ML-1:0] ch_msg_len,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [1:0]    rsp_status,
  input  logic [1:0]    rsp_ack,
  input  logic [LW-1:0] rsp_len,
  input  logic [DW-1:0] rsp_data,
  output logic          done,
  output logic [2:0]    done_code,
  output logic [LW-1:0] rd_count,
  output logic [DW-1:0] rd_data
);
  localparam int WAIT_RAW = CLK_FREQ / 2500;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int TW       = $clog2(MAX_TRIES + 1);

  auxq_state_e   st;
  logic          is_wr;
  logic [LW-1:0] len_q;
  logic [MW-1:0] msg_q;
  logic [ML-1:0] msglen_q;
  logic [TW-1:0] tries;
  logic [MW-1:0] hdr_msg;
  logic [ML-1:0] hdr_len;
  logic          bad_len, last, fin, go_send, go_wait, rsp_fire, tmr_exp;
  logic [2:0]    fcode;
  logic [LW-1:0] clamp;
  logic [DW-1:0] rd_next;

  auxq_hdr #(.MAXB(MAXB), .LW(LW), .ML(ML), .MW(MW), .DW(DW)) u_hdr (
    .is_write(req_write), .addr(req_addr), .len(req_len), .wdata(req_wdata),
    .msg(hdr_msg), .msg_len(hdr_len)
  );

  assign rsp_fire = (st == ST_WRSP) && rsp_valid;

  auxq_timer #(.W(WAIT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .start(rsp_fire && go_wait), .run(st == ST_WDEF),
    .expired(tmr_exp)
  );

  assign bad_len    = (req_len == '0) || (req_len > LW'(MAXB));
  assign req_ready  = (st == ST_IDLE);
  assign ch_valid   = (st == ST_SEND);
  assign rsp_ready  = (st == ST_WRSP);
  assign ch_msg     = msg_q;
  assign ch_msg_len = msglen_q;

  always_comb begin
    fin     = 1'b0;
    fcode   = RES_OK;
    go_send = 1'b0;
    go_wait = 1'b0;
    last    = (tries == TW'(MAX_TRIES - 1));
    clamp   = (rsp_len > len_q) ? len_q : rsp_len;
    case (rsp_status)
      CH_TIMEOUT: begin fin = 1'b1; fcode = RES_TIMEOUT; end
      CH_ERROR:   begin fin = 1'b1; fcode = RES_IO; end
      CH_BUSY: begin
        if (last) begin fin = 1'b1; fcode = RES_IO; end
        else go_send = 1'b1;
      end
      default: begin
        case (rsp_ack)
          ACK_OK: begin
            fin = 1'b1;
            if (!is_wr && rsp_len == '0) fcode = RES_PROTO;
          end
          ACK_DEFER: begin
            if (last) begin fin = 1'b1; fcode = RES_IO; end
            else go_wait = 1'b1;
          end
          default: begin fin = 1'b1; fcode = RES_IO; end
        endcase
      end
    endcase
    for (int i = 0; i < MAXB; i++)
      rd_next[8*i +: 8] = (!is_wr && i < int'(clamp)) ? rsp_data[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; is_wr <= 1'b0; len_q <= '0; msg_q <= '0; msglen_q <= '0;
      tries <= '0; done <= 1'b0; done_code <= RES_OK; rd_count <= '0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          if (bad_len) begin
            done <= 1'b1; done_code <= RES_REJECT; rd_count <= '0; rd_data <= '0;
          end else begin
            is_wr <= req_write; len_q <= req_len; msg_q <= hdr_msg;
            msglen_q <= hdr_len; tries <= '0; st <= ST_SEND;
          end
        end
        ST_SEND: if (ch_ready) st <= ST_WRSP;
        ST_WRSP: if (rsp_valid) begin
          if (fin) begin
            done      <= 1'b1;
            done_code <= fcode;
            rd_count  <= (fcode != RES_OK) ? '0 : (is_wr ? len_q : clamp);
            rd_data   <= (fcode == RES_OK) ? rd_next : '0;
            st        <= ST_IDLE;
          end else begin
            tries <= tries + TW'(1);
            st    <= go_wait ? ST_WDEF : ST_SEND;
          end
        end
        ST_WDEF: if (tmr_exp) st <= ST_SEND;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_msg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && !ch_ready) |=> (ch_valid && $stable(ch_msg)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idle_excl_R11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!ch_valid && !rsp_ready));
  assert_attempt_cap_R7: assert property (@(posedge clk) disable iff (rst)
    tries < TW'(MAX_TRIES));
  assert_busy_resend_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_fire && rsp_status == CH_BUSY && !last) |=> ch_valid);
  assert_fatal_end_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_fire && rsp_status == CH_TIMEOUT) |=> (done && done_code == RES_TIMEOUT));
  assert_read_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    (done && done_code == RES_OK) |-> (rd_count != '0));
endmodule

// File: tb/test_auxq_seq.sv
module test_auxq_seq;
  localparam int MAXB = 16;
  localparam int CLK_FREQ = 100_000;
  localparam int MAX_TRIES = 4;
  localparam int W  = CLK_FREQ / 2500;
  localparam int LW = $clog2(MAXB + 1);
  localparam int ML = $clog2(MAXB + 5);
  localparam int MW = 8 * (MAXB + 4);
  localparam int DW = 8 * MAXB;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, ch_ready = 1, rsp_valid = 0;
  logic [15:0] req_addr = '0;
  logic [LW-1:0] req_len = '0, rsp_len = '0;
  logic [DW-1:0] req_wdata = '0, rsp_data = '0;
  logic [1:0] rsp_status = '0, rsp_ack = '0;
  logic req_ready, ch_valid, rsp_ready, done;
  logic [MW-1:0] ch_msg;
  logic [ML-1:0] ch_msg_len;
  logic [2:0] done_code;
  logic [LW-1:0] rd_count;
  logic [DW-1:0] rd_data;

  int nchk = 0, nfail = 0, ndone = 0, cyc = 0;
  int sc_st[8], sc_ack[8], sc_len[8];
  logic [DW-1:0] sc_dat[8];

  always #10 clk = ~clk;

  auxq_seq #(.MAXB(MAXB), .CLK_FREQ(CLK_FREQ), .MAX_TRIES(MAX_TRIES)) i_auxq_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .ch_valid(ch_valid), .ch_ready(ch_ready),
    .ch_msg(ch_msg), .ch_msg_len(ch_msg_len), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_ack(rsp_ack),
    .rsp_len(rsp_len), .rsp_data(rsp_data), .done(done), .done_code(done_code),
    .rd_count(rd_count), .rd_data(rd_data)
  );

  always @(negedge clk) if (!rst && done) ndone++;

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic chk(string tag, logic [MW-1:0] act, logic [MW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] exp_msg(bit wr, logic [15:0] a, int len, logic [DW-1:0] wd);
    logic [MW-1:0] m = '0;
    int tot = wr ? len + 4 : 4;
    m[7:0] = a[7:0];
    m[15:8] = a[15:8];
    m[23:16] = wr ? 8'h80 : 8'h90;
    m[31:24] = 8'((((tot & 15) << 4) | ((len - 1) & 15)));
    if (wr) for (int i = 0; i < len; i++) m[32+8*i +: 8] = wd[8*i +: 8];
    return m;
  endfunction

  task automatic set_rsp(int k, int s, int a, int l, logic [DW-1:0] d);
    sc_st[k] = s; sc_ack[k] = a; sc_len[k] = l; sc_dat[k] = d;
  endtask

  // Reference model: policy replayed on the scripted replies.
  task automatic run(string tag, bit wr, logic [15:0] a, int len, logic [DW-1:0] wd);
    int att = 0, code = 0, cnt = 0, n0, g;
    int gap[8];
    bit stop = 0;
    logic [DW-1:0] ed = '0;
    if (len == 0 || len > MAXB) begin code = 4; stop = 1; end
    gap[0] = 0;
    while (!stop) begin
      att++;
      if (sc_st[att-1] == 1) begin code = 1; stop = 1; end
      else if (sc_st[att-1] == 3) begin code = 2; stop = 1; end
      else if (sc_st[att-1] == 2) begin
        if (att == MAX_TRIES) begin code = 2; stop = 1; end else gap[att] = 0;
      end else if (sc_ack[att-1] == 0) begin
        stop = 1;
        if (!wr && sc_len[att-1] == 0) code = 3;
        else if (wr) cnt = len;
        else begin
          cnt = (sc_len[att-1] < len) ? sc_len[att-1] : len;
          for (int i = 0; i < cnt; i++) ed[8*i +: 8] = sc_dat[att-1][8*i +: 8];
        end
      end else if (sc_ack[att-1] == 2) begin
        if (att == MAX_TRIES) begin code = 2; stop = 1; end else gap[att] = W;
      end else begin code = 2; stop = 1; end
    end
    n0 = ndone;
    req_valid = 1; req_write = wr; req_addr = a; req_len = LW'(len); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (att == 0) chk({tag, " R3 no request"}, MW'(ch_valid), '0);
    for (int k = 0; k < att; k++) begin
      g = 0;
      while (!ch_valid && g < 2000) begin @(negedge clk); g++; end
      chk({tag, (k == 0) ? " R5 first issue gap" : (gap[k] == 0 ? " R5 busy gap" : " R6 defer gap")},
          MW'(g), MW'(gap[k]));
      chk({tag, " R1 message"}, ch_msg, exp_msg(wr, a, len, wd));
      chk({tag, " R2 length"}, MW'(ch_msg_len), MW'(wr ? len + 4 : 4));
      @(negedge clk);
      rsp_valid = 1; rsp_status = 2'(sc_st[k]); rsp_ack = 2'(sc_ack[k]);
      rsp_len = LW'(sc_len[k]); rsp_data = sc_dat[k];
      @(negedge clk);
      rsp_valid = 0;
    end
    chk({tag, " R4 R7 R8 done due"}, MW'(done), MW'(1));
    chk({tag, " R4 R8 R9 code"}, MW'(done_code), MW'(code));
    chk({tag, " R10 count"}, MW'(rd_count), MW'(cnt));
    chk({tag, " R10 data"}, MW'(rd_data), MW'(ed));
    @(negedge clk); #1;
    chk({tag, " R11 single pulse"}, MW'(ndone - n0), MW'(1));
    chk({tag, " R11 idle"}, MW'({done, req_ready}), MW'(1));
    @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] pat;
    pat = '0;
    for (int i = 0; i < MAXB; i++) pat[8*i +: 8] = 8'(8'hA0 + i);
    repeat (3) @(negedge clk);
    rst = 0;
    chk("reset R11", MW'({req_ready, ch_valid, rsp_ready, done}), MW'(4'b1000));
    set_rsp(0, 0, 0, 0, '0);
    run("wr1", 1, 16'h0102, 1, pat);
    run("wr16", 1, 16'h0600, 16, pat);
    run("wr17 R3", 1, 16'h0001, 17, pat);
    run("rd0 R3", 0, 16'h0001, 0, '0);
    set_rsp(0, 0, 0, 8, ~pat);
    run("rd8", 0, 16'h0000, 8, '0);
    set_rsp(0, 0, 0, 9, pat);
    run("rd clamp", 0, 16'h0202, 4, '0);
    set_rsp(0, 0, 0, 0, pat);
    run("rd empty R9", 0, 16'h0202, 2, '0);
    set_rsp(0, 2, 0, 0, '0); set_rsp(1, 2, 0, 0, '0); set_rsp(2, 0, 0, 2, pat);
    run("busy busy ok", 0, 16'h0100, 2, '0);
    set_rsp(0, 0, 2, 0, '0); set_rsp(1, 0, 0, 0, '0);
    run("defer ok", 1, 16'h0103, 3, pat);
    for (int k = 0; k < 4; k++) set_rsp(k, 2, 0, 0, '0);
    run("busy x4 R7", 1, 16'h0100, 1, pat);
    set_rsp(0, 0, 2, 0, '0); set_rsp(1, 2, 0, 0, '0); set_rsp(2, 0, 2, 0, '0); set_rsp(3, 0, 2, 0, '0);
    run("mixed x4 R7", 0, 16'h0100, 1, '0);
    set_rsp(0, 1, 0, 0, '0);
    run("timeout", 0, 16'h0001, 1, '0);
    set_rsp(0, 3, 0, 0, '0);
    run("error", 0, 16'h0001, 1, '0);
    set_rsp(0, 0, 1, 0, '0);
    run("nack", 1, 16'h0001, 1, pat);
    set_rsp(0, 0, 3, 0, '0);
    run("bad ack", 0, 16'h0001, 1, '0);
    summary();
  end
endmodule